// File: doc/BRIEF.md
# Trap Entry Vector Sequencer

This block is the hardware front end of trap handling in a processor core. Synchronous faults (instruction access fault, illegal instruction, system call, page fault) and asynchronous interrupt requests all go through one shared entry path. In a single clock edge the block picks the winning request and records the current and next program counter. It moves the processor into supervisor mode, keeping the old mode bit, and clears the trap-enable flag. It also forms the handler fetch address from a software-programmed base register.

The handler address has three parts. The upper twenty bits come from the base register. An 8-bit trap type sits in the middle, and the four lowest bits are zero, so each handler gets a 16-byte slot of four 32-bit words. Software writes the base once, on a 4 KiB boundary. Hardware fills the type field, which software can then read back. If a synchronous fault arrives while trap-enable is clear, the block does not vector. It pulses a watchdog reset request instead. A one-cycle pulse tells an outside register-window unit to step its window pointer. A return-from-trap input sets trap-enable again and restores the previous mode.

Top module: `trap_entry_seq`

## Requirements
- R1: A synchronous fault or an allowed interrupt taken at a clock edge produces, after that edge, a one-cycle `trap_taken_o` pulse and the same entry effects, whichever kind it is.
- R2: On trap entry `super_o` becomes 1, `prev_super_o` takes the value `super_o` held before the entry, and `saved_pc_o` / `saved_npc_o` take `pc_i` / `npc_i` from the entry cycle.
- R3: Trap entry clears `et_o`. While `et_o` is 0, interrupt requests are ignored: no trap, no watchdog pulse, and no change to the saved state.
- R4: A synchronous request while `et_o` is 0 pulses `wdog_rst_o` for one cycle, produces no trap, and leaves the saved PCs, mode bits and `tbr_o` unchanged.
- R5: `vector_o` = {base[31:12], type[7:0], 4'b0000}. With base 0x4000, type 1 gives 0x4010 and type 2 gives 0x4020.
- R6: `tbr_o[31:12]` is written only by `tbr_wr_i`, `tbr_o[11:4]` holds the type of the last trap taken, and `tbr_o[3:0]` reads 0. A base write in the same cycle as a trap entry takes effect after it: that trap uses the old base.
- R7: Priority: `sync_req_i` bit i has type i+1 and the lowest set bit wins. Any synchronous request beats interrupts. `irq_req_i` bit j is level j+1 with type 0x10+j+1, and the highest set bit wins.
- R8: `rett_i` sets `et_o` to 1 and copies `prev_super_o` into `super_o`. A trap entry in the same cycle takes precedence and `rett_i` is dropped.
- R9: `win_dec_o` pulses in exactly the cycles in which `trap_taken_o` pulses.
- R10: After reset: `et_o`=0, `super_o`=1, `prev_super_o`=0, and all pulses, the saved PCs, `vector_o` and `tbr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req_i | input | NSYNC | Synchronous fault requests, bit 0 highest priority |
| irq_req_i | input | NIRQ | Interrupt requests, bit j is level j+1 |
| pc_i | input | 32 | Program counter of the current instruction |
| npc_i | input | 32 | Next program counter |
| rett_i | input | 1 | Return from trap: re-enable traps and restore the mode |
| tbr_wr_i | input | 1 | Base register write strobe |
| tbr_wdata_i | input | 32 | Base write data, bits 31:12 used |
| trap_taken_o | output | 1 | One-cycle trap entry pulse |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |
| win_dec_o | output | 1 | Window pointer step request |
| vector_o | output | 32 | Handler fetch address of the last trap |
| saved_pc_o | output | 32 | Saved program counter |
| saved_npc_o | output | 32 | Saved next program counter |
| tbr_o | output | 32 | Base register readback |
| et_o | output | 1 | Trap enable |
| super_o | output | 1 | Supervisor mode |
| prev_super_o | output | 1 | Previous supervisor mode |

## Verification
Two things can happen at the same edge: a software base write or a return-from-trap, and a trap entry. The bench forces both pairs in directed cycles. It then checks that the vector uses the old base while `tbr_o` shows the new base with the new type. It also checks that a coincident return is dropped, so `et_o` stays 0. Random cycles then mix base writes, returns, faults and interrupts freely, and every output is compared each cycle against a bench model.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int XLEN     = 32;
  localparam int TT_W     = 8;
  localparam int SLOT_LSB = 4;
  localparam int BASE_LSB = SLOT_LSB + TT_W;
  localparam int BASE_W   = XLEN - BASE_LSB;

  function automatic logic [XLEN-1:0] make_vector(input logic [BASE_W-1:0] base,
                                                  input logic [TT_W-1:0] tt);
    return {base, tt, {SLOT_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/trap_prio.sv
module trap_prio
  import trap_seq_pkg::*;
#(
  parameter int NSYNC    = 4,
  parameter int NIRQ     = 15,
  parameter int SYNC_TT0 = 1,
  parameter int IRQ_TT0  = 16
) (
  input  logic [NSYNC-1:0]      sync_req,
  input  logic [NIRQ-1:0]       irq_req,
  input  logic                  irq_allow,
  output logic                  any_sync,
  output logic                  take_any,
  output logic [TT_W-1:0]       sel_tt,
  output logic [NSYNC+NIRQ-1:0] grant
);
  localparam int NALL = NSYNC + NIRQ;

  logic any_irq;

  always_comb begin
    any_sync = |sync_req;
    any_irq  = irq_allow && (|irq_req);
    take_any = any_sync || any_irq;
    sel_tt   = '0;
    grant    = '0;
    // interrupts: ascending scan, highest level overwrites
    if (irq_allow && !any_sync) begin
      for (int j = 0; j < NIRQ; j++) begin
        if (irq_req[j]) begin
          sel_tt = TT_W'(IRQ_TT0 + j + 1);
          grant  = NALL'(1) << (NSYNC + j);
        end
      end
    end
    // synchronous: descending scan, lowest index overwrites
    for (int i = NSYNC - 1; i >= 0; i--) begin
      if (sync_req[i]) begin
        sel_tt = TT_W'(SYNC_TT0 + i);
        grant  = NALL'(1) << i;
      end
    end
  end
endmodule

// File: rtl/trap_base_reg.sv
module trap_base_reg
  import trap_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             tt_load,
  input  logic [TT_W-1:0]  tt_in,
  output logic [BASE_W-1:0] base_q,
  output logic [XLEN-1:0]  tbr_q
);
  logic [TT_W-1:0] tt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      tt_q   <= '0;
    end else begin
      if (wr_en)   base_q <= wr_data[XLEN-1:BASE_LSB];
      if (tt_load) tt_q   <= tt_in;
    end
  end

  assign tbr_q = {base_q, tt_q, {SLOT_LSB{1'b0}}};

  assert_base_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tbr_q[XLEN-1:BASE_LSB] == $past(wr_data[XLEN-1:BASE_LSB]));
  assert_type_capture_R6: assert property (@(posedge clk) disable iff (rst)
    tt_load |=> tbr_q[BASE_LSB-1:SLOT_LSB] == $past(tt_in));
endmodule

// File: rtl/trap_mode_state.sv
module trap_mode_state (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic rett,
  output logic et,
  output logic sup,
  output logic psup
);
  always_ff @(posedge clk) begin
    if (rst) begin
      et   <= 1'b0;
      sup  <= 1'b1;
      psup <= 1'b0;
    end else if (enter) begin
      et   <= 1'b0;
      psup <= sup;
      sup  <= 1'b1;
    end else if (rett) begin
      et  <= 1'b1;
      sup <= psup;
    end
  end

  assert_entry_clears_et_R3: assert property (@(posedge clk) disable iff (rst)
    enter |=> !et);
  assert_entry_mode_R2: assert property (@(posedge clk) disable iff (rst)
    enter |=> (sup && psup == $past(sup)));
  assert_return_R8: assert property (@(posedge clk) disable iff (rst)
    (rett && !enter) |=> (et && sup == $past(psup)));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NSYNC    = 4,
  parameter int NIRQ     = 15,
  parameter int SYNC_TT0 = 1,
  parameter int IRQ_TT0  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSYNC-1:0] sync_req_i,
  input  logic [NIRQ-1:0]  irq_req_i,
  input  logic [31:0]      pc_i,
  input  logic [31:0]      npc_i,
  input  logic             rett_i,
  input  logic             tbr_wr_i,
  input  logic [31:0]      tbr_wdata_i,
  output logic             trap_taken_o,
  output logic             wdog_rst_o,
  output logic             win_dec_o,
  output logic [31:0]      vector_o,
  output logic [31:0]      saved_pc_o,
  output logic [31:0]      saved_npc_o,
  output logic [31:0]      tbr_o,
  output logic             et_o,
  output logic             super_o,
  output logic             prev_super_o
);
  logic                  any_sync, take_any, trap_go, wdog_go;
  logic [TT_W-1:0]       sel_tt;
  logic [NSYNC+NIRQ-1:0] grant;
  logic [BASE_W-1:0]     base_q;

  trap_prio #(.NSYNC(NSYNC), .NIRQ(NIRQ), .SYNC_TT0(SYNC_TT0), .IRQ_TT0(IRQ_TT0)) u_prio (
    .sync_req(sync_req_i), .irq_req(irq_req_i), .irq_allow(et_o),
    .any_sync(any_sync), .take_any(take_any), .sel_tt(sel_tt), .grant(grant));

  assign trap_go = et_o && take_any;
  assign wdog_go = !et_o && any_sync;

  trap_base_reg u_tbr (
    .clk(clk), .rst(rst), .wr_en(tbr_wr_i), .wr_data(tbr_wdata_i),
    .tt_load(trap_go), .tt_in(sel_tt), .base_q(base_q), .tbr_q(tbr_o));

  trap_mode_state u_mode (
    .clk(clk), .rst(rst), .enter(trap_go), .rett(rett_i),
    .et(et_o), .sup(super_o), .psup(prev_super_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_taken_o <= 1'b0;
      wdog_rst_o   <= 1'b0;
      win_dec_o    <= 1'b0;
      vector_o     <= '0;
      saved_pc_o   <= '0;
      saved_npc_o  <= '0;
    end else begin
      trap_taken_o <= trap_go;
      wdog_rst_o   <= wdog_go;
      win_dec_o    <= trap_go;
      if (trap_go) begin
        vector_o    <= make_vector(base_q, sel_tt);
        saved_pc_o  <= pc_i;
        saved_npc_o <= npc_i;
      end
    end
  end

  assert_one_winner_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_wdog_no_vector_R4: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |-> !trap_taken_o);
  assert_wdog_keeps_pc_R4: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |-> $stable(saved_pc_o));
  assert_vector_slot_R5: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> (vector_o[11:4] == tbr_o[11:4] && vector_o[3:0] == 4'h0));
  assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
    (!et_o && !(|sync_req_i)) |=> !trap_taken_o);
  assert_window_step_R9: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> win_dec_o);
  assert_entry_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> (super_o && !et_o));
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  localparam int NS = 4;
  localparam int NI = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] sync_req = '0;
  logic [NI-1:0] irq_req = '0;
  logic [31:0] pc = '0, npc = '0, wdata = '0;
  logic rett = 1'b0, tbr_wr = 1'b0;
  logic taken, wdog, wdec, et, sup, psup;
  logic [31:0] vec, spc, snpc, tbr;

  int checks = 0, fails = 0;

  // model state
  logic m_et, m_sup, m_psup, m_taken, m_wdog;
  logic [19:0] m_base;
  logic [7:0]  m_tt;
  logic [31:0] m_vec, m_spc, m_snpc;

  trap_entry_seq u0 (
    .clk(clk), .rst(rst), .sync_req_i(sync_req), .irq_req_i(irq_req),
    .pc_i(pc), .npc_i(npc), .rett_i(rett), .tbr_wr_i(tbr_wr), .tbr_wdata_i(wdata),
    .trap_taken_o(taken), .wdog_rst_o(wdog), .win_dec_o(wdec), .vector_o(vec),
    .saved_pc_o(spc), .saved_npc_o(snpc), .tbr_o(tbr), .et_o(et),
    .super_o(sup), .prev_super_o(psup));

  always #2 clk = ~clk;

  function automatic logic [7:0] ref_tt(input logic [NS-1:0] s, input logic [NI-1:0] q);
    for (int i = 0; i < NS; i++) if (s[i]) return 8'(i + 1);
    for (int j = NI - 1; j >= 0; j--) if (q[j]) return 8'(16 + j + 1);
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 trap_taken", 32'(taken), 32'(m_taken));
    chk("R4 wdog_rst", 32'(wdog), 32'(m_wdog));
    chk("R9 win_dec", 32'(wdec), 32'(m_taken));
    chk("R5 vector", vec, m_vec);
    chk("R2 saved_pc", spc, m_spc);
    chk("R2 saved_npc", snpc, m_snpc);
    chk("R6 tbr", tbr, {m_base, m_tt, 4'h0});
    chk("R3 et", 32'(et), 32'(m_et));
    chk("R8 super", 32'(sup), 32'(m_sup));
    chk("R2 prev_super", 32'(psup), 32'(m_psup));
  endtask

  // inputs are set at a negedge; model advances; outputs checked next negedge
  task automatic cyc(input logic [NS-1:0] s, input logic [NI-1:0] q, input logic rt,
                     input logic wr, input logic [31:0] wd);
    logic go, any_s;
    sync_req = s; irq_req = q; rett = rt; tbr_wr = wr; wdata = wd;
    pc = $urandom; npc = pc + 32'd4;
    any_s = |s;
    go = m_et && (any_s || (|q));
    m_wdog = !m_et && any_s;
    m_taken = go;
    if (go) begin
      m_tt = ref_tt(s, q);
      m_vec = {m_base, m_tt, 4'h0};
      m_spc = pc; m_snpc = npc;
      m_et = 1'b0; m_psup = m_sup; m_sup = 1'b1;
    end else if (rt) begin
      m_et = 1'b1; m_sup = m_psup;
    end
    if (wr) m_base = wd[31:12];
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    m_et = 0; m_sup = 1; m_psup = 0; m_taken = 0; m_wdog = 0;
    m_base = '0; m_tt = '0; m_vec = '0; m_spc = '0; m_snpc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check_all();
    chk("R10 et after reset", 32'(et), 32'd0);
    chk("R10 super after reset", 32'(sup), 32'd1);
    // R6 low bits masked on write
    cyc('0, '0, 0, 1, 32'h0000_4ABC);
    chk("R6 tbr low masked", tbr, 32'h0000_4000);
    // R4 fault while disabled
    cyc(4'b0001, '0, 0, 0, 0);
    chk("R4 wdog pulse", 32'(wdog), 32'd1);
    cyc('0, '0, 0, 0, 0);
    // R3 interrupt ignored while disabled
    cyc('0, 15'h7FFF, 0, 0, 0);
    chk("R3 irq ignored", 32'(taken | wdog), 32'd0);
    // R8 return enables traps
    cyc('0, '0, 1, 0, 0);
    // R5 type 1 and 2 vectors
    cyc(4'b0001, '0, 0, 0, 0);
    chk("R5 vector type1", vec, 32'h0000_4010);
    cyc('0, '0, 1, 0, 0);
    cyc(4'b0010, '0, 0, 0, 0);
    chk("R5 vector type2", vec, 32'h0000_4020);
    cyc('0, '0, 1, 0, 0);
    // R7 priority among faults and over interrupts
    cyc(4'b1110, 15'h0101, 0, 0, 0);
    chk("R7 lowest sync wins", vec, 32'h0000_4020);
    cyc('0, '0, 1, 0, 0);
    cyc('0, 15'b000_0010_0000_0100, 0, 0, 0);
    chk("R7 highest irq wins", vec, 32'h0000_41A0);
    // R8 trap beats coincident return
    cyc('0, '0, 1, 0, 0);
    cyc(4'b0100, '0, 1, 0, 0);
    chk("R8 trap beats rett", 32'(et), 32'd0);
    // R6 base write with trap: old base vectors
    cyc('0, '0, 1, 0, 0);
    cyc(4'b1000, '0, 0, 1, 32'h0009_9000);
    chk("R6 old base used", vec, 32'h0000_4040);
    chk("R6 new base shown", tbr, 32'h0009_9040);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [NS-1:0] s;
      logic [NI-1:0] q;
      s = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      q = (($urandom % 3) == 0) ? NI'($urandom) : '0;
      cyc(s, q, ($urandom % 3) == 0, ($urandom % 8) == 0, $urandom);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule